// File: doc/BRIEF.md
# Interrupt Controller with Acknowledged Claim

This block gathers a handful of level-sensitive interrupt requests and presents them to two targets. Each target has its own interrupt line. Software on a target reads that target's claim register to learn which source to service. The claim read is speculation-safe: the read only reports an ID and has no side effect on the sources. The claimed source's pending state is consumed only when a one-cycle acknowledge pulse arrives on that target's acknowledge input. That pulse confirms that the claim read truly retired.

Once serviced, software writes the same ID to the target's complete register. The source is then held off for a programmable number of cycles before it may pend again. Sources carry a priority and a per-target enable. Each target carries a threshold. All of these are reached through a simple request/write-enable register port, and read data appears one cycle after the request.

Top module: `plic_ack_ctrl`

## Requirements
- R1: Source input bit n is reported as ID n+1. A claim read returns the ID of the best eligible pending source for that target, or 0 when there is none.
- R2: A read request returns its data with `rvalid_o` high exactly one cycle after the request. `rvalid_o` is low in every cycle after a non-read.
- R3: Among eligible pending sources, the one with the highest priority is chosen. Equal priorities resolve to the lowest ID.
- R4: A source is eligible for a target only if its enable bit for that target is set and its priority is strictly above that target's threshold, so priority 0 never interrupts. The target's `irq_o` bit is high exactly when an eligible pending source exists.
- R5: A claim read not followed by an acknowledge leaves the source pending, even after its input drops. A repeated claim read returns the same ID.
- R6: An `ack_i` pulse on a target clears the pending state of the ID most recently returned by a claim read on that target, and that target's line falls if nothing else is eligible. An acknowledge with no outstanding claim read has no effect.
- R7: A claimed source that has not been completed does not pend again, even with its input held high.
- R8: A complete write whose ID does not match a source in service for that same target is ignored.
- R9: After a valid complete write, the source cannot pend again until the hold-off count has elapsed. The hold-off count is the number of cycles held off, and re-pending occurs on the cycle after the count reaches zero.
- R10: The two targets have independent enables, thresholds, claims and outputs.
- R11: After reset, all registers are zero, no source is pending and both interrupt lines are low.
- R12: Register map (6-bit address, 8-bit data):
  - 0x00+n: priority of source n, bits 2:0.
  - 0x10+t: enable mask of target t, bit n for source n.
  - 0x18+t: threshold of target t.
  - 0x20+t: claim (read) and complete (write) for target t.
  - 0x28: hold-off cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level interrupt requests |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the request |
| addr_i | input | 6 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| ack_i | input | NUM_TGT | Per-target claim retirement pulse |
| irq_o | output | NUM_TGT | Per-target interrupt line |

## Verification
On every cycle the assertions check the following:
- the read-data timing;
- that a pending bit falls only on the cycle after an acknowledge;
- that an in-service source is never pending;
- that no source re-pends while its hold-off counter is running;
- that a raised interrupt line always has a pending source behind it.

The bench scenarios alone can show the remaining behaviour:
- which ID wins under mixed priorities, enables and thresholds;
- that an unacknowledged claim keeps returning the same ID;
- that mismatched completes are ignored;
- the exact extent of the hold-off window;
- the independence of the two targets.

// File: rtl/plic_ack_pkg.sv
package plic_ack_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] PRIO_BASE  = 6'h00;
    localparam logic [ADDR_W-1:0] EN_BASE    = 6'h10;
    localparam logic [ADDR_W-1:0] THR_BASE   = 6'h18;
    localparam logic [ADDR_W-1:0] CLAIM_BASE = 6'h20;
    localparam logic [ADDR_W-1:0] HOLD_ADDR  = 6'h28;
endpackage

// File: rtl/plic_ack_gate.sv
// Per-source level gateway: pending, in-service and hold-off counter.
module plic_ack_gate #(
    parameter int HOLD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              src_i,
    input  logic              take_i,
    input  logic              done_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              pend_o,
    output logic              active_o,
    output logic              busy_o
);
    typedef struct packed {
        logic              pend;
        logic              active;
        logic [HOLD_W-1:0] cnt;
    } gate_t;

    gate_t q, d;

    always_comb begin
        d = q;
        if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
        if (take_i) begin
            d.pend   = 1'b0;
            d.active = 1'b1;
        end
        if (done_i) begin
            d.active = 1'b0;
            d.cnt    = hold_len_i;
        end
        if (src_i && !q.pend && !q.active && q.cnt == '0) d.pend = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign pend_o   = q.pend;
    assign active_o = q.active;
    assign busy_o   = (q.cnt != '0);
endmodule

// File: rtl/plic_ack_pick.sv
// Selects the highest-priority eligible source above threshold; ties to lowest ID.
module plic_ack_pick #(
    parameter int NUM_SRC = 4,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 3
) (
    input  logic [NUM_SRC-1:0]             elig_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [ID_W-1:0]                id_o
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        best = thr_i;
        id_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig_i[i] && prio_i[i] > best) begin
                best = prio_i[i];
                id_o = ID_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/plic_ack_ctrl.sv
module plic_ack_ctrl
    import plic_ack_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_TGT = 2,
    parameter int PRIO_W  = 3,
    parameter int HOLD_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [5:0]         addr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    output logic               rvalid_o,
    input  logic [NUM_TGT-1:0] ack_i,
    output logic [NUM_TGT-1:0] irq_o
);
    localparam int ID_W  = $clog2(NUM_SRC + 1);
    localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_TGT-1:0][NUM_SRC-1:0] en;
        logic [NUM_TGT-1:0][PRIO_W-1:0]  thr;
        logic [NUM_TGT-1:0][ID_W-1:0]    last;
        logic [NUM_SRC-1:0][TGT_W-1:0]   owner;
        logic [HOLD_W-1:0]               hold;
        logic [DATA_W-1:0]               rdata;
        logic                            rvalid;
    } state_t;

    state_t q, d;

    logic [NUM_SRC-1:0]           pend, active, busy, take, done;
    logic [NUM_TGT-1:0][ID_W-1:0] best_id;

    always_comb begin
        d        = q;
        take     = '0;
        done     = '0;
        d.rvalid = req_i && !we_i;

        // acknowledge: retire the most recent claim of each target
        for (int t = 0; t < NUM_TGT; t++) begin
            if (ack_i[t]) begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (q.last[t] == ID_W'(i + 1) && pend[i] && !take[i]) begin
                        take[i]    = 1'b1;
                        d.owner[i] = TGT_W'(t);
                    end
                end
                d.last[t] = '0;
            end
        end

        if (req_i && we_i) begin
            for (int i = 0; i < NUM_SRC; i++)
                if (addr_i == ADDR_W'(PRIO_BASE + i)) d.prio[i] = wdata_i[PRIO_W-1:0];
            for (int t = 0; t < NUM_TGT; t++) begin
                if (addr_i == ADDR_W'(EN_BASE + t))  d.en[t]  = wdata_i[NUM_SRC-1:0];
                if (addr_i == ADDR_W'(THR_BASE + t)) d.thr[t] = wdata_i[PRIO_W-1:0];
                if (addr_i == ADDR_W'(CLAIM_BASE + t)) begin
                    for (int i = 0; i < NUM_SRC; i++)
                        if (wdata_i == DATA_W'(i + 1) && active[i] && q.owner[i] == TGT_W'(t))
                            done[i] = 1'b1;
                end
            end
            if (addr_i == HOLD_ADDR) d.hold = wdata_i[HOLD_W-1:0];
        end

        if (req_i && !we_i) begin
            d.rdata = '0;
            for (int i = 0; i < NUM_SRC; i++)
                if (addr_i == ADDR_W'(PRIO_BASE + i)) d.rdata[PRIO_W-1:0] = q.prio[i];
            for (int t = 0; t < NUM_TGT; t++) begin
                if (addr_i == ADDR_W'(EN_BASE + t))  d.rdata[NUM_SRC-1:0] = q.en[t];
                if (addr_i == ADDR_W'(THR_BASE + t)) d.rdata[PRIO_W-1:0]  = q.thr[t];
                if (addr_i == ADDR_W'(CLAIM_BASE + t)) begin
                    d.rdata[ID_W-1:0] = best_id[t];
                    d.last[t]         = best_id[t];
                end
            end
            if (addr_i == HOLD_ADDR) d.rdata[HOLD_W-1:0] = q.hold;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        plic_ack_gate #(.HOLD_W(HOLD_W)) u_gate (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .src_i     (src_i[i]),
            .take_i    (take[i]),
            .done_i    (done[i]),
            .hold_len_i(q.hold),
            .pend_o    (pend[i]),
            .active_o  (active[i]),
            .busy_o    (busy[i])
        );
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        plic_ack_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
            .elig_i(pend & q.en[t]),
            .prio_i(q.prio),
            .thr_i (q.thr[t]),
            .id_o  (best_id[t])
        );
        assign irq_o[t] = |best_id[t];
    end

    assign rdata_o  = q.rdata;
    assign rvalid_o = q.rvalid;
endmodule

// File: rtl/plic_ack_ctrl_chk.sv
module plic_ack_ctrl_chk #(
    parameter int NUM_SRC = 4,
    parameter int NUM_TGT = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               req_i,
    input logic               we_i,
    input logic               rvalid_i,
    input logic [NUM_TGT-1:0] ack_i,
    input logic [NUM_TGT-1:0] irq_i,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] active_i,
    input logic [NUM_SRC-1:0] busy_i
);
    assert_read_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_i == $past(req_i && !we_i));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        assert_fall_needs_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(pend_i[i]) |-> $past(|ack_i));
        assert_no_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            active_i[i] |-> !pend_i[i]);
        assert_holdoff_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(pend_i[i]) |-> $past(!busy_i[i]));
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tchk
        assert_irq_backed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_i[t] |-> (|pend_i));
    end
endmodule

bind plic_ack_ctrl plic_ack_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .rvalid_i(rvalid_o),
    .ack_i   (ack_i),
    .irq_i   (irq_o),
    .pend_i  (pend),
    .active_i(active),
    .busy_i  (busy)
);

// File: tb/plic_ack_ctrl_test.sv
`timescale 1ns/1ps
module plic_ack_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src = '0;
    logic       req = 1'b0, we = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rvalid;
    logic [1:0] ack = '0;
    logic [1:0] irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    plic_ack_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .ack_i(ack), .irq_o(irq)
    );

    typedef struct packed {
        logic [15:0] prio;  // nibble n = priority of source n
        logic [3:0]  en;
        logic [2:0]  thr;
        logic [3:0]  src;
        logic [2:0]  exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h4321, 4'hF, 3'd0, 4'hF, 3'd4},
        '{16'h2222, 4'hF, 3'd0, 4'hA, 3'd2},
        '{16'h6765, 4'hB, 3'd0, 4'hF, 3'd2},
        '{16'h3545, 4'hF, 3'd5, 4'hF, 3'd0},
        '{16'h1000, 4'hF, 3'd0, 4'h1, 3'd0},
        '{16'h7133, 4'hF, 3'd2, 4'h7, 3'd1}
    };

    task automatic check(input string req_tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src = '0; req = 1'b0; ack = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] v);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v, output logic vld);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        v = rdata; vld = rvalid;
    endtask

    task automatic pulse_ack(input int t);
        @(negedge clk);
        ack[t] = 1'b1;
        @(negedge clk);
        ack = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       vld;

        // R11: reset state
        do_reset();
        @(negedge clk);
        check("R11 irq after reset", int'(irq), 0);
        rd(6'h20, v, vld);
        check("R11 claim after reset", int'(v), 0);
        check("R2 rvalid one cycle after read", int'(vld), 1);
        @(negedge clk);
        check("R2 rvalid low after idle", int'(rvalid), 0);

        // R3/R4/R12: table of priority, enable, threshold scenarios on target 0
        foreach (VECS[k]) begin
            do_reset();
            for (int n = 0; n < 4; n++) wr(6'(n), {5'b0, VECS[k].prio[4*n +: 3]});
            wr(6'h10, {4'b0, VECS[k].en});
            wr(6'h18, {5'b0, VECS[k].thr});
            @(negedge clk);
            src = VECS[k].src;
            idle(2);
            rd(6'h20, v, vld);
            check($sformatf("R3 R4 vector %0d claim id", k), int'(v), int'(VECS[k].exp));
            check($sformatf("R4 vector %0d irq line", k), int'(irq[0]), int'(VECS[k].exp != 0));
        end

        // Directed: claim, acknowledge, complete, hold-off, two targets
        do_reset();
        wr(6'h00, 8'd1);
        wr(6'h01, 8'd2);
        wr(6'h10, 8'h1);
        wr(6'h11, 8'h2);
        wr(6'h28, 8'd5);
        rd(6'h28, v, vld);
        check("R12 hold register readback", int'(v), 5);
        @(negedge clk);
        src = 4'b0001;
        idle(2);
        check("R10 only target 0 raised", int'(irq), 1);
        rd(6'h20, v, vld);
        check("R1 source 0 reports ID 1", int'(v), 1);
        rd(6'h20, v, vld);
        check("R5 repeated claim same ID", int'(v), 1);
        check("R5 line held without ack", int'(irq[0]), 1);
        src = 4'b0000;
        idle(3);
        check("R5 pending kept after input drop", int'(irq[0]), 1);

        pulse_ack(0);
        check("R6 ack clears line", int'(irq[0]), 0);
        rd(6'h20, v, vld);
        check("R6 claim empty after ack", int'(v), 0);

        src = 4'b0001;
        idle(4);
        check("R7 no re-raise while in service", int'(irq[0]), 0);

        wr(6'h20, 8'd2);
        idle(8);
        check("R8 wrong ID complete ignored", int'(irq[0]), 0);
        wr(6'h21, 8'd1);
        idle(8);
        check("R8 wrong target complete ignored", int'(irq[0]), 0);

        wr(6'h20, 8'd1);
        idle(2);
        check("R9 held off after complete", int'(irq[0]), 0);
        idle(8);
        check("R9 re-raised after hold-off", int'(irq[0]), 1);

        @(negedge clk);
        src = 4'b0011;
        idle(2);
        check("R10 target 1 raised", int'(irq[1]), 1);
        pulse_ack(1);
        check("R6 ack without claim ignored", int'(irq[1]), 1);
        rd(6'h21, v, vld);
        check("R10 target 1 claims ID 2", int'(v), 2);
        pulse_ack(1);
        check("R10 target 1 cleared", int'(irq[1]), 0);
        check("R10 target 0 unaffected", int'(irq[0]), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule